// File: doc/BRIEF.md
# Word Stack Engine

This block runs a last-in, first-out stack of 16-bit words on top of a byte-wide memory. The stack lives in one segment whose base is supplied as an input. The byte address of any stack location is that base shifted left by four bits, plus the stack pointer. The stack grows toward lower addresses. The pointer always names the most recently filled word, and a pointer value of all ones except bit 0 (FFFEh at the default width) means the stack is empty.

A push splits the word into two byte writes. The low byte goes to the lower address. A pop issues two byte reads to a memory with one cycle of read latency, rebuilds the word and presents it with a valid strobe. While a command runs, the engine raises `busy` and ignores new requests. It pulses `done` when the command is complete. A push that would carry the pointer below zero is refused with an overflow pulse. A pop from an empty stack is refused with an underflow pulse. The memory side is a plain synchronous port that block RAM can serve directly.

Top module: `wstk_engine`

## Requirements
- R1: After reset, `sp_out` equals the empty value (2^PTR_W - 2), and `busy`, `done`, `pop_valid`, `overflow`, `underflow`, `mem_wr_en` and `mem_rd_en` are all 0.
- R2: An accepted push lowers the pointer by 2 on its accept edge, before any byte is written, and then stores the word at the new pointer.
- R3: Word bytes are little-endian: bits 7:0 go to the even address base+sp, and bits 15:8 go to base+sp+1. `mem_addr[0]` is 0 for the low-byte access and 1 for the high-byte access.
- R4: Every memory address equals (seg_base << 4) + sp, plus 1 for the high byte, modulo 2^(SEG_W+4). The segment is sampled when the command is accepted.
- R5: An accepted pop reads the word at the current pointer and returns it on `pop_word` with a one-cycle `pop_valid`. The pointer rises by 2 in the same cycle.
- R6: A pop while the stack is empty gives a one-cycle `underflow` pulse. It does not raise `busy`, does not access memory, does not pulse `pop_valid`, and leaves the pointer unchanged.
- R7: A push while the pointer is below 2 gives a one-cycle `overflow` pulse. It does not raise `busy`, does not write memory, and leaves the pointer unchanged.
- R8: A push holds `busy` for exactly 2 cycles with two write cycles (low byte, then high byte). A pop holds `busy` for exactly 3 cycles with two read cycles. `done` is a one-cycle pulse in the cycle where `busy` falls.
- R9: Push and pop requests that arrive while `busy` is high are ignored.
- R10: When push and pop are requested in the same idle cycle, the push is taken and the pop is dropped.
- R11: The stack pointer is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_base | input | SEG_W | Stack segment base, shifted left 4 bits to form the byte address |
| push_req | input | 1 | Request to push `push_word` |
| push_word | input | 2*BYTE_W | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| pop_valid | output | 1 | One-cycle pulse when `pop_word` is new |
| pop_word | output | 2*BYTE_W | Word returned by the last pop |
| overflow | output | 1 | Push refused because the stack is full |
| underflow | output | 1 | Pop refused because the stack is empty |
| sp_out | output | PTR_W | Current stack pointer |
| mem_addr | output | SEG_W+4 | Byte address to memory |
| mem_wr_en | output | 1 | Byte write enable |
| mem_rd_en | output | 1 | Byte read enable (data returns one cycle later) |
| mem_wdata | output | BYTE_W | Byte write data |
| mem_rdata | input | BYTE_W | Byte read data |

## Verification
The bench builds the engine with PTR_W=4 and SEG_W=4. This gives a seven-word stack and sixteen disjoint 16-byte segments in a 256-byte memory, so every segment can be filled to its limit and drained. Each segment is swept through a full fill, a refused push, a full drain and a refused pop. The expected bytes, addresses, words and pointer values are computed from the segment and position. A busy-time request, a simultaneous request and an interleaved push/pop order are exercised on chosen segments.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_FIN
  } seq_state_t;

  localparam int unsigned SEG_SHIFT = 4;
endpackage

// File: rtl/wstk_ptr.sv
module wstk_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec,
  input  logic             inc,
  output logic [PTR_W-1:0] sp,
  output logic             at_empty,
  output logic             at_floor
);
  localparam logic [PTR_W-1:0] SP_EMPTY = {{(PTR_W-1){1'b1}}, 1'b0};
  localparam logic [PTR_W-1:0] STEP     = PTR_W'(2);

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_EMPTY;
    else if (dec) sp <= sp - STEP;
    else if (inc) sp <= sp + STEP;
  end

  assign at_empty = (sp == SP_EMPTY);
  assign at_floor = (sp < STEP);

  // R11
  sp_even_chk: assert property (@(posedge clk) disable iff (rst) !sp[0]);
  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    dec |=> sp == $past(sp) - STEP);
  // R5
  pop_inc_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> sp == $past(sp) + STEP);
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> sp >= STEP);
  // R6
  no_under_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> sp != SP_EMPTY);
endmodule

// File: rtl/wstk_addr.sv
module wstk_addr
  import wstk_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = SEG_W + 4
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              hi,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;

  assign base = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
  assign addr = base + ADDR_W'(ptr) + ADDR_W'(hi);
endmodule

// File: rtl/wstk_seq.sv
module wstk_seq
  import wstk_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int SEG_W  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [WORD_W-1:0] push_word,
  input  logic [SEG_W-1:0]  seg_base,
  input  logic [PTR_W-1:0]  sp,
  input  logic              sp_empty,
  input  logic              sp_floor,
  output logic              ptr_dec,
  output logic              ptr_inc,
  output logic [SEG_W-1:0]  seg_q,
  output logic [PTR_W-1:0]  tgt_q,
  output logic              hi_sel,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] pop_word,
  output logic              pop_valid,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic              underflow
);
  seq_state_t        st;
  logic [BYTE_W-1:0] hi_byte_q;
  logic [BYTE_W-1:0] lo_byte_q;
  logic              idle;
  logic              take_push;
  logic              take_pop;

  assign idle      = (st == ST_IDLE);
  assign take_push = idle && push_req && !sp_floor;
  assign take_pop  = idle && !push_req && pop_req && !sp_empty;
  assign ptr_dec   = take_push;
  assign ptr_inc   = (st == ST_RD_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      seg_q     <= '0;
      tgt_q     <= '0;
      hi_sel    <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wdata <= '0;
      hi_byte_q <= '0;
      lo_byte_q <= '0;
      pop_word  <= '0;
      pop_valid <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done      <= 1'b0;
      pop_valid <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (push_req) begin
            if (sp_floor) begin
              overflow <= 1'b1;
            end else begin
              seg_q     <= seg_base;
              tgt_q     <= sp - PTR_W'(2);
              hi_sel    <= 1'b0;
              mem_wr_en <= 1'b1;
              mem_wdata <= push_word[BYTE_W-1:0];
              hi_byte_q <= push_word[WORD_W-1:BYTE_W];
              busy      <= 1'b1;
              st        <= ST_WR_LO;
            end
          end else if (pop_req) begin
            if (sp_empty) begin
              underflow <= 1'b1;
            end else begin
              seg_q     <= seg_base;
              tgt_q     <= sp;
              hi_sel    <= 1'b0;
              mem_rd_en <= 1'b1;
              busy      <= 1'b1;
              st        <= ST_RD_LO;
            end
          end
        end
        ST_WR_LO: begin
          hi_sel    <= 1'b1;
          mem_wdata <= hi_byte_q;
          st        <= ST_WR_HI;
        end
        ST_WR_HI: begin
          mem_wr_en <= 1'b0;
          hi_sel    <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_RD_LO: begin
          hi_sel <= 1'b1;
          st     <= ST_RD_HI;
        end
        ST_RD_HI: begin
          mem_rd_en <= 1'b0;
          hi_sel    <= 1'b0;
          lo_byte_q <= mem_rdata;
          st        <= ST_RD_FIN;
        end
        ST_RD_FIN: begin
          pop_word  <= {mem_rdata, lo_byte_q};
          pop_valid <= 1'b1;
          busy      <= 1'b0;
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && mem_rd_en));
  // R8
  wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && !hi_sel) |=> (mem_wr_en && hi_sel));
  // R8
  rd_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !hi_sel) |=> (mem_rd_en && hi_sel));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R6
  underflow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (!busy && !pop_valid && !mem_rd_en));
  // R7
  overflow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!busy && !mem_wr_en));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && $past(busy)) |-> $stable(tgt_q));
endmodule

// File: rtl/wstk_engine.sv
module wstk_engine #(
  parameter int PTR_W  = 16,
  parameter int SEG_W  = 16,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = SEG_W + 4,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEG_W-1:0]  seg_base,
  input  logic              push_req,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop_req,
  output logic              busy,
  output logic              done,
  output logic              pop_valid,
  output logic [WORD_W-1:0] pop_word,
  output logic              overflow,
  output logic              underflow,
  output logic [PTR_W-1:0]  sp_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic             ptr_dec;
  logic             ptr_inc;
  logic             sp_empty;
  logic             sp_floor;
  logic [SEG_W-1:0] seg_q;
  logic [PTR_W-1:0] tgt_q;
  logic             hi_sel;

  wstk_ptr #(.PTR_W(PTR_W)) ptr_i (
    .clk      (clk),
    .rst      (rst),
    .dec      (ptr_dec),
    .inc      (ptr_inc),
    .sp       (sp_out),
    .at_empty (sp_empty),
    .at_floor (sp_floor)
  );

  wstk_seq #(.PTR_W(PTR_W), .SEG_W(SEG_W), .BYTE_W(BYTE_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_word (push_word),
    .seg_base  (seg_base),
    .sp        (sp_out),
    .sp_empty  (sp_empty),
    .sp_floor  (sp_floor),
    .ptr_dec   (ptr_dec),
    .ptr_inc   (ptr_inc),
    .seg_q     (seg_q),
    .tgt_q     (tgt_q),
    .hi_sel    (hi_sel),
    .mem_wr_en (mem_wr_en),
    .mem_rd_en (mem_rd_en),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .pop_word  (pop_word),
    .pop_valid (pop_valid),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow),
    .underflow (underflow)
  );

  wstk_addr #(.SEG_W(SEG_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) addr_i (
    .seg  (seg_q),
    .ptr  (tgt_q),
    .hi   (hi_sel),
    .addr (mem_addr)
  );

  // R3
  addr_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en || mem_rd_en) |-> (mem_addr[0] == hi_sel));
  // R5
  valid_done_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> done);
endmodule

// File: tb/wstk_engine_tb_top.sv
module wstk_engine_tb_top;
  localparam int PW = 4;
  localparam int SW = 4;
  localparam int AW = SW + 4;
  localparam logic [PW-1:0] EMPTY = 4'd14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] seg_base = '0;
  logic          push_req = 1'b0;
  logic [15:0]   push_word = '0;
  logic          pop_req = 1'b0;
  logic          busy, done, pop_valid, overflow, underflow;
  logic [15:0]   pop_word;
  logic [PW-1:0] sp_out;
  logic [AW-1:0] mem_addr;
  logic          mem_wr_en, mem_rd_en;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;

  logic [7:0]    bmem [0:255];
  int            wr_cnt, rd_cnt;
  int            n_chk = 0;
  int            n_bad = 0;
  int            m_sp = 14;
  logic [15:0]   stored [0:15];

  always #5 clk = ~clk;

  wstk_engine #(.PTR_W(PW), .SEG_W(SW), .BYTE_W(8)) dut_i (
    .clk(clk), .rst(rst), .seg_base(seg_base), .push_req(push_req),
    .push_word(push_word), .pop_req(pop_req), .busy(busy), .done(done),
    .pop_valid(pop_valid), .pop_word(pop_word), .overflow(overflow),
    .underflow(underflow), .sp_out(sp_out), .mem_addr(mem_addr),
    .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'hA5;
      wr_cnt    <= 0;
      rd_cnt    <= 0;
      mem_rdata <= '0;
    end else begin
      if (mem_wr_en) begin
        bmem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd_en) begin
        mem_rdata <= bmem[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] gen(input int s, input int k);
    return 16'(((s << 12) | (k << 8) | ((s * 7 + k * 29 + 3) & 8'hFF)) ^ 16'h5A3C);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // also_pop: pop requested with the push (R10); late_pop: pop during busy (R9)
  task automatic push_op(input int s, input logic [15:0] w, input bit also_pop, input bit late_pop);
    int wr0, rd0, cyc, a;
    wr0 = wr_cnt; rd0 = rd_cnt;
    seg_base = SW'(s); push_word = w; push_req = 1'b1; pop_req = also_pop;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    if (m_sp < 2) begin
      chk("R7 overflow pulse", int'(overflow), 1);
      chk("R7 busy stays low", int'(busy), 0);
      @(negedge clk);
      chk("R7 overflow one cycle", int'(overflow), 0);
      chk("R7 pointer unchanged", int'(sp_out), m_sp);
      chk("R7 no write", wr_cnt - wr0, 0);
      chk("R7 wrap byte untouched", int'(bmem[s*16+14]), int'(8'(s*16+14) ^ 8'hA5));
    end else begin
      m_sp -= 2;
      cyc = 1;
      chk("R2 pointer lowered on accept", int'(sp_out), m_sp);
      chk("R2 nothing written yet", wr_cnt - wr0, 0);
      chk("R8 push busy", int'(busy), 1);
      if (late_pop) begin
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        cyc++;
      end
      while (!done && cyc < 12) begin
        @(negedge clk);
        cyc++;
      end
      chk("R8 push done on third cycle", cyc, 3);
      chk("R8 busy low with done", int'(busy), 0);
      chk("R8 two byte writes", wr_cnt - wr0, 2);
      a = s * 16 + m_sp;
      chk("R3 low byte at lower address", int'(bmem[a]), int'(w[7:0]));
      chk("R4 high byte at next address", int'(bmem[a+1]), int'(w[15:8]));
      stored[m_sp] = w;
      if (also_pop || late_pop) begin
        @(negedge clk);
        chk(also_pop ? "R10 push wins, no read" : "R9 busy pop ignored", rd_cnt - rd0, 0);
        chk("R9 pointer after ignored pop", int'(sp_out), m_sp);
        chk("R9 no pop strobe", int'(pop_valid), 0);
      end
    end
  endtask

  task automatic pop_op(input int s);
    int rd0, wr0, cyc;
    rd0 = rd_cnt; wr0 = wr_cnt;
    seg_base = SW'(s); pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    if (m_sp == int'(EMPTY)) begin
      chk("R6 underflow pulse", int'(underflow), 1);
      chk("R6 busy stays low", int'(busy), 0);
      chk("R6 no pop strobe", int'(pop_valid), 0);
      @(negedge clk);
      chk("R6 underflow one cycle", int'(underflow), 0);
      chk("R6 pointer unchanged", int'(sp_out), m_sp);
      chk("R6 no read", rd_cnt - rd0, 0);
    end else begin
      cyc = 1;
      chk("R8 pop busy", int'(busy), 1);
      while (!done && cyc < 12) begin
        @(negedge clk);
        cyc++;
      end
      chk("R8 pop done on fourth cycle", cyc, 4);
      chk("R8 two byte reads", rd_cnt - rd0, 2);
      chk("R8 no write during pop", wr_cnt - wr0, 0);
      chk("R5 pop strobe", int'(pop_valid), 1);
      chk("R5 popped word", int'(pop_word), int'(stored[m_sp]));
      m_sp += 2;
      chk("R5 pointer raised", int'(sp_out), m_sp);
      @(negedge clk);
      chk("R5 strobe one cycle", int'(pop_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pointer", int'(sp_out), int'(EMPTY));
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset flags", int'({pop_valid, overflow, underflow}), 0);
    chk("R1 reset memory strobes", int'({mem_wr_en, mem_rd_en}), 0);
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 7; k++)
        push_op(s, gen(s, k), (s == 5 && k == 4), (s == 3 && k == 2));
      chk("R11 full pointer even", int'(sp_out[0]), 0);
      push_op(s, 16'hDEAD, 1'b0, 1'b0);
      for (int k = 0; k < 7; k++) pop_op(s);
      pop_op(s);
    end
    push_op(10, 16'h1234, 1'b0, 1'b0);
    push_op(10, 16'hBEEF, 1'b0, 1'b0);
    pop_op(10);
    push_op(10, 16'h0F0F, 1'b0, 1'b0);
    pop_op(10);
    pop_op(10);
    chk("R5 interleave ends empty", int'(sp_out), int'(EMPTY));
    summary();
    $finish;
  end
endmodule